// File: doc/BRIEF.md
# Morphable Pipelined DSP Datapath Unit

This block is a reconfigurable arithmetic unit. It takes four signed 16-bit operands and returns two 16-bit results through a five-stage pipeline. A 3-bit context code, normally supplied each cycle by a context store, sets the operation for that input. The operations are multiply-accumulate into a 32-bit accumulator, a real-weight butterfly, an add tree, sum-of-differences, difference-of-sums, a 16-bit LFSR, a loadable step counter and a signed comparator. A `restart` input goes with each operand set. In multiply-accumulate mode it starts a fresh accumulation. In LFSR and counter modes it loads a value from operand 0.

The arithmetic modes form a 32-bit intermediate. The last stages turn it back into 16 bits: an arithmetic right shift picks a 16-bit window, and the window saturates when the shifted value does not fit. The LFSR, counter and comparator modes produce native 16-bit values and skip the window stage. Input routing, twiddle generation and operand storage belong to the surrounding fabric.

Top module: `morph_dpu`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly five clock cycles. Only inputs with `in_valid` high change internal state.
- R2: While `rst_n` is low and afterwards, until valid data arrives, `out_valid`, `res0` and `res1` are 0.
- R3: Mode 0 (multiply-accumulate) forms p = op0·op1 (signed). The accumulator becomes p when `restart` is 1 and acc+p otherwise, wrapping at 32 bits. `res0` is the conditioned accumulator and `res1` is the conditioned p.
- R4: Mode 1 (butterfly) forms p = op1·op2. `res0` is the conditioned op0+p and `res1` is the conditioned op0−p.
- R5: Mode 2 (add tree): `res0` is the conditioned op0+op1+op2+op3 and `res1` is the conditioned op0+op1.
- R6: Mode 3 (sum of differences) gives (op0−op1)+(op2−op3) on `res0` and op0−op1 on `res1`. Mode 4 (difference of sums) gives (op0+op1)−(op2+op3) on `res0` and op0+op1 on `res1`. Both results are conditioned.
- R7: Conditioning is an arithmetic right shift of the 32-bit value by `win_sel` (0..15), keeping bits 15:0 of the shifted value.
- R8: If the shifted value is above 32767 the result is 0x7FFF. If it is below −32768 the result is 0x8000.
- R9: Mode 5 (LFSR) uses a 16-bit state. It loads op0 when `restart` is 1 and otherwise steps once as {s[14:0], s[15]^s[13]^s[12]^s[10]} (polynomial x^16+x^14+x^13+x^11+1). `res0` is the new state and `res1` is the state before the update. No window or saturation is applied.
- R10: Mode 6 (counter) uses a 16-bit count. It loads op0 when `restart` is 1 and otherwise adds op1, wrapping modulo 2^16. `res0` is the new count. `res1` is 1 when the new count equals op2 and 0 otherwise. No window or saturation is applied.
- R11: Mode 7 (compare) works on op0 and op1 as signed values. `res0` is the larger of the two. `res1` bits 2:0 are {gt, eq, lt} and its upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set is valid this cycle |
| mode | input | 3 | Context code selecting the operation |
| restart | input | 1 | Accumulator clear, or LFSR/counter load |
| win_sel | input | 4 | Right-shift amount for the output window |
| op0 | input | 16 | Operand 0 |
| op1 | input | 16 | Operand 1 |
| op2 | input | 16 | Operand 2 |
| op3 | input | 16 | Operand 3 |
| out_valid | output | 1 | Results are valid |
| res0 | output | 16 | Primary result |
| res1 | output | 16 | Secondary result |

## Verification
The bench targets the following corner cases:
- **Saturation at both extremes.** A design that fails to clamp wraps the value and flips its sign.
- **A window shift of 15 on a large product.** A logical shift here loses the sign of negative values.
- **Accumulation runs broken by `restart` and by invalid cycles.** A design that updates state on bubbles, or that adds when it should reload, drifts from the expected sum.
- **Counter wrap-around with a match flag, an LFSR sequence from a known seed, and compares with equal operands.** These expose wrong tap positions, wrong wrap behaviour and misplaced flag bits.

Randomly mixed modes arriving back to back check that each result leaves exactly five cycles after its input, with no data from a neighbouring input.

// File: rtl/mdpu_pkg.sv
// Shared definitions for the morphable datapath unit.
// Assumes the LFSR is always 16 bits wide, whatever the operand width.
package mdpu_pkg;

    typedef enum logic [2:0] {
        MD_MAC  = 3'd0,
        MD_BFLY = 3'd1,
        MD_TREE = 3'd2,
        MD_SOD  = 3'd3,
        MD_DOS  = 3'd4,
        MD_LFSR = 3'd5,
        MD_CNT  = 3'd6,
        MD_CMP  = 3'd7
    } md_mode_e;

    // One Fibonacci step of x^16+x^14+x^13+x^11+1
    function automatic logic [15:0] lfsr16_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/mdpu_prep.sv
// Stages 1 and 2: registers the operand set, then forms the single product
// and the four pairwise sums and differences used by the later stages.
// Assumes operands are two's complement. The product operands depend on the mode.
module mdpu_prep
    import mdpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             mode,
    input  logic                   restart,
    input  logic [SW-1:0]          win_sel,
    input  logic [DW-1:0]          op0,
    input  logic [DW-1:0]          op1,
    input  logic [DW-1:0]          op2,
    input  logic [DW-1:0]          op3,
    output logic                   s2_valid,
    output md_mode_e               s2_mode,
    output logic                   s2_restart,
    output logic [SW-1:0]          s2_win,
    output logic signed [2*DW-1:0] s2_prod,
    output logic signed [DW:0]     s2_pa,
    output logic signed [DW:0]     s2_pd,
    output logic signed [DW:0]     s2_qa,
    output logic signed [DW:0]     s2_qd,
    output logic signed [DW-1:0]   s2_x0,
    output logic signed [DW-1:0]   s2_x1,
    output logic signed [DW-1:0]   s2_x2
);
    localparam int PW = 2 * DW;
    localparam int EW = DW + 1;

    logic                 s1_valid;
    md_mode_e             s1_mode;
    logic                 s1_restart;
    logic [SW-1:0]        s1_win;
    logic signed [DW-1:0] s1_op [4];
    logic signed [DW-1:0] mul_a, mul_b;
    logic signed [PW-1:0] prod_c;

    // Stage 1: capture the operand set and its context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_mode    <= MD_MAC;
            s1_restart <= 1'b0;
            s1_win     <= '0;
            for (int i = 0; i < 4; i++) s1_op[i] <= '0;
        end else begin
            s1_valid   <= in_valid;
            s1_mode    <= md_mode_e'(mode);
            s1_restart <= restart;
            s1_win     <= win_sel;
            s1_op[0]   <= op0;
            s1_op[1]   <= op1;
            s1_op[2]   <= op2;
            s1_op[3]   <= op3;
        end
    end

    // Pick the multiplier operands: the butterfly weights op1 by op2
    always_comb begin
        mul_a  = (s1_mode == MD_BFLY) ? s1_op[1] : s1_op[0];
        mul_b  = (s1_mode == MD_BFLY) ? s1_op[2] : s1_op[1];
        prod_c = PW'(mul_a) * PW'(mul_b);
    end

    // Stage 2: register the product and the pairwise sums and differences
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid   <= 1'b0;
            s2_mode    <= MD_MAC;
            s2_restart <= 1'b0;
            s2_win     <= '0;
            s2_prod    <= '0;
            s2_pa      <= '0;
            s2_pd      <= '0;
            s2_qa      <= '0;
            s2_qd      <= '0;
            s2_x0      <= '0;
            s2_x1      <= '0;
            s2_x2      <= '0;
        end else begin
            s2_valid   <= s1_valid;
            s2_mode    <= s1_mode;
            s2_restart <= s1_restart;
            s2_win     <= s1_win;
            s2_prod    <= prod_c;
            s2_pa      <= EW'(s1_op[0]) + EW'(s1_op[1]);
            s2_pd      <= EW'(s1_op[0]) - EW'(s1_op[1]);
            s2_qa      <= EW'(s1_op[2]) + EW'(s1_op[3]);
            s2_qd      <= EW'(s1_op[2]) - EW'(s1_op[3]);
            s2_x0      <= s1_op[0];
            s2_x1      <= s1_op[1];
            s2_x2      <= s1_op[2];
        end
    end

endmodule

// File: rtl/mdpu_fold.sv
// Stage 3: combines the stage-2 terms according to the mode and owns all
// state (accumulator, LFSR, counter). State changes only for valid inputs.
// Assumes AW >= 2*DW, so that a product always fits.
module mdpu_fold
    import mdpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s2_valid,
    input  md_mode_e               s2_mode,
    input  logic                   s2_restart,
    input  logic [SW-1:0]          s2_win,
    input  logic signed [2*DW-1:0] s2_prod,
    input  logic signed [DW:0]     s2_pa,
    input  logic signed [DW:0]     s2_pd,
    input  logic signed [DW:0]     s2_qa,
    input  logic signed [DW:0]     s2_qd,
    input  logic signed [DW-1:0]   s2_x0,
    input  logic signed [DW-1:0]   s2_x1,
    input  logic signed [DW-1:0]   s2_x2,
    output logic                   s3_valid,
    output logic                   s3_raw,
    output logic [SW-1:0]          s3_win,
    output logic signed [AW-1:0]   s3_wide [2],
    output logic [DW-1:0]          s3_nat [2]
);
    localparam int LW = 16;

    logic signed [AW-1:0] acc_q, acc_nx, psx, ax;
    logic [LW-1:0]        lf_q, lf_nx;
    logic [DW-1:0]        ct_q, ct_nx;
    logic signed [AW-1:0] w0, w1;
    logic [DW-1:0]        n0, n1;
    logic                 gt, eq, lt;

    // Mode decode: wide results for arithmetic modes, native ones otherwise
    always_comb begin
        psx    = AW'(s2_prod);
        ax     = AW'(s2_x0);
        acc_nx = acc_q;
        lf_nx  = lf_q;
        ct_nx  = ct_q;
        w0     = '0;
        w1     = '0;
        n0     = '0;
        n1     = '0;
        gt     = s2_x0 > s2_x1;
        eq     = s2_x0 == s2_x1;
        lt     = s2_x0 < s2_x1;
        unique case (s2_mode)
            MD_MAC: begin
                acc_nx = s2_restart ? psx : acc_q + psx;
                w0     = acc_nx;
                w1     = psx;
            end
            MD_BFLY: begin
                w0 = ax + psx;
                w1 = ax - psx;
            end
            MD_TREE: begin
                w0 = AW'(s2_pa) + AW'(s2_qa);
                w1 = AW'(s2_pa);
            end
            MD_SOD: begin
                w0 = AW'(s2_pd) + AW'(s2_qd);
                w1 = AW'(s2_pd);
            end
            MD_DOS: begin
                w0 = AW'(s2_pa) - AW'(s2_qa);
                w1 = AW'(s2_pa);
            end
            MD_LFSR: begin
                lf_nx = s2_restart ? LW'(s2_x0) : lfsr16_next(lf_q);
                n0    = DW'(lf_nx);
                n1    = DW'(lf_q);
            end
            MD_CNT: begin
                ct_nx = s2_restart ? DW'(s2_x0) : ct_q + DW'(s2_x1);
                n0    = ct_nx;
                n1    = {{(DW-1){1'b0}}, ct_nx == DW'(s2_x2)};
            end
            default: begin
                n0 = gt ? DW'(s2_x0) : DW'(s2_x1);
                n1 = {{(DW-3){1'b0}}, gt, eq, lt};
            end
        endcase
    end

    // Persistent state: updated only when a valid input reaches this stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            lf_q  <= '0;
            ct_q  <= '0;
        end else if (s2_valid) begin
            acc_q <= acc_nx;
            lf_q  <= lf_nx;
            ct_q  <= ct_nx;
        end
    end

    // Stage 3 register toward output conditioning
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_valid <= 1'b0;
            s3_raw   <= 1'b0;
            s3_win   <= '0;
            for (int c = 0; c < 2; c++) begin
                s3_wide[c] <= '0;
                s3_nat[c]  <= '0;
            end
        end else begin
            s3_valid   <= s2_valid;
            s3_raw     <= s2_mode inside {MD_LFSR, MD_CNT, MD_CMP};
            s3_win     <= s2_win;
            s3_wide[0] <= w0;
            s3_wide[1] <= w1;
            s3_nat[0]  <= n0;
            s3_nat[1]  <= n1;
        end
    end

endmodule

// File: rtl/mdpu_outcond.sv
// Stages 4 and 5: shifts each wide result right arithmetically to pick a
// 16-bit window, notes overflow, then saturates. Native results pass as is.
// Assumes the shift amount never exceeds AW-DW.
module mdpu_outcond #(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s3_valid,
    input  logic                 s3_raw,
    input  logic [SW-1:0]        s3_win,
    input  logic signed [AW-1:0] s3_wide [2],
    input  logic [DW-1:0]        s3_nat [2],
    output logic                 out_valid,
    output logic [DW-1:0]        res [2]
);
    localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SAT_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam int            TW      = AW - DW + 1;

    logic signed [AW-1:0] shv [2];
    logic [TW-1:0]        top [2];
    logic                 s4_valid;
    logic [DW-1:0]        s4_lo  [2];
    logic                 s4_ovf [2];
    logic                 s4_neg [2];

    // Window shift for both channels
    always_comb begin
        for (int c = 0; c < 2; c++) begin
            shv[c] = s3_wide[c] >>> s3_win;
            top[c] = shv[c][AW-1:DW-1];
        end
    end

    // Stage 4: register the window slice and the out-of-range flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s4_valid <= 1'b0;
            for (int c = 0; c < 2; c++) begin
                s4_lo[c]  <= '0;
                s4_ovf[c] <= 1'b0;
                s4_neg[c] <= 1'b0;
            end
        end else begin
            s4_valid <= s3_valid;
            for (int c = 0; c < 2; c++) begin
                s4_lo[c]  <= s3_raw ? s3_nat[c] : shv[c][DW-1:0];
                s4_ovf[c] <= !s3_raw && !((&top[c]) || !(|top[c]));
                s4_neg[c] <= s3_wide[c][AW-1];
            end
        end
    end

    // Stage 5: saturate and drive the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int c = 0; c < 2; c++) res[c] <= '0;
        end else begin
            out_valid <= s4_valid;
            for (int c = 0; c < 2; c++)
                res[c] <= s4_ovf[c] ? (s4_neg[c] ? SAT_NEG : SAT_POS) : s4_lo[c];
        end
    end

endmodule

// File: rtl/morph_dpu.sv
// Top of the morphable datapath unit: five register stages, mode chosen per
// input by a context code. Assumes that the operand routing and the context
// store sit outside.
module morph_dpu #(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic          restart,
    input  logic [SW-1:0] win_sel,
    input  logic [DW-1:0] op0,
    input  logic [DW-1:0] op1,
    input  logic [DW-1:0] op2,
    input  logic [DW-1:0] op3,
    output logic          out_valid,
    output logic [DW-1:0] res0,
    output logic [DW-1:0] res1
);
    import mdpu_pkg::*;

    logic                   s2_valid, s2_restart;
    md_mode_e               s2_mode;
    logic [SW-1:0]          s2_win;
    logic signed [2*DW-1:0] s2_prod;
    logic signed [DW:0]     s2_pa, s2_pd, s2_qa, s2_qd;
    logic signed [DW-1:0]   s2_x0, s2_x1, s2_x2;
    logic                   s3_valid, s3_raw;
    logic [SW-1:0]          s3_win;
    logic signed [AW-1:0]   s3_wide [2];
    logic [DW-1:0]          s3_nat [2];
    logic [DW-1:0]          res [2];

    mdpu_prep #(.DW(DW), .SW(SW)) u_prep (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .restart(restart), .win_sel(win_sel),
        .op0(op0), .op1(op1), .op2(op2), .op3(op3),
        .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_restart(s2_restart),
        .s2_win(s2_win), .s2_prod(s2_prod), .s2_pa(s2_pa), .s2_pd(s2_pd),
        .s2_qa(s2_qa), .s2_qd(s2_qd), .s2_x0(s2_x0), .s2_x1(s2_x1), .s2_x2(s2_x2)
    );

    mdpu_fold #(.DW(DW), .AW(AW), .SW(SW)) u_fold (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_restart(s2_restart),
        .s2_win(s2_win), .s2_prod(s2_prod), .s2_pa(s2_pa), .s2_pd(s2_pd),
        .s2_qa(s2_qa), .s2_qd(s2_qd), .s2_x0(s2_x0), .s2_x1(s2_x1), .s2_x2(s2_x2),
        .s3_valid(s3_valid), .s3_raw(s3_raw), .s3_win(s3_win),
        .s3_wide(s3_wide), .s3_nat(s3_nat)
    );

    mdpu_outcond #(.DW(DW), .AW(AW), .SW(SW)) u_cond (
        .clk(clk), .rst_n(rst_n), .s3_valid(s3_valid), .s3_raw(s3_raw),
        .s3_win(s3_win), .s3_wide(s3_wide), .s3_nat(s3_nat),
        .out_valid(out_valid), .res(res)
    );

    assign res0 = res[0];
    assign res1 = res[1];

endmodule

// File: rtl/mdpu_chk.sv
// Property checker for the morphable datapath unit, bound to its top.
// Looks back five cycles only once five cycles have passed since reset.
module mdpu_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    mode,
    input logic          restart,
    input logic [DW-1:0] op0,
    input logic [DW-1:0] op1,
    input logic          out_valid,
    input logic [DW-1:0] res0,
    input logic [DW-1:0] res1
);
    logic [2:0] seen;

    // Count cycles since reset release, saturating at five
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else if (seen != 3'd5) seen <= seen + 3'd1;
    end

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 3'd5) |-> (out_valid == $past(in_valid, 5)));

    // R11: exactly one compare flag, upper bits clear
    p_cmp_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 3'd5 && $past(in_valid && mode == 3'd7, 5))
        |-> ($onehot(res1[2:0]) && res1[DW-1:3] == '0));

    p_cmp_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 3'd5 && $past(in_valid && mode == 3'd7, 5))
        |-> (res0 == (($signed($past(op0, 5)) > $signed($past(op1, 5)))
                      ? $past(op0, 5) : $past(op1, 5))));

    p_lfsr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 3'd5 && $past(in_valid && restart && mode == 3'd5, 5))
        |-> (res0 == $past(op0, 5)));

    p_cnt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 3'd5 && $past(in_valid && restart && mode == 3'd6, 5))
        |-> (res0 == $past(op0, 5)));

endmodule

bind morph_dpu mdpu_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .restart(restart), .op0(op0), .op1(op1), .out_valid(out_valid),
    .res0(res0), .res1(res1)
);

// File: tb/morph_dpu_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random mixed modes.
module morph_dpu_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, restart;
    logic [2:0]  mode;
    logic [3:0]  win_sel;
    logic [15:0] op0, op1, op2, op3;
    logic        out_valid;
    logic [15:0] res0, res1;

    always #2.5 clk = ~clk;

    morph_dpu u_morph_dpu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .restart(restart), .win_sel(win_sel),
        .op0(op0), .op1(op1), .op2(op2), .op3(op3),
        .out_valid(out_valid), .res0(res0), .res1(res1)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // Reference state
    int          m_acc;
    logic [15:0] m_lf, m_ct;

    // Expected results in flight, indexed by issue cycle modulo 8
    bit          ev [8];
    logic [15:0] e0 [8];
    logic [15:0] e1 [8];
    string       et [8];

    function automatic logic [15:0] cond(input int w, input int sh);
        int s;
        s = w >>> sh;
        if (s > 32767)  return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    function automatic logic [15:0] lf_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One cycle: check the result of the input issued five cycles ago, then drive
    task automatic issue(input bit v, input logic [2:0] m, input bit rs, input int w,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] d);
        int sa, sb, sc, sd, p, k, s;
        logic [15:0] old;
        @(negedge clk);
        if (cyc >= 5) begin
            s = (cyc + 3) % 8;
            check("R1 out_valid", {15'b0, out_valid}, {15'b0, ev[s]});
            if (ev[s]) begin
                check({et[s], " res0"}, res0, e0[s]);
                check({et[s], " res1"}, res1, e1[s]);
            end
        end
        in_valid = v; mode = m; restart = rs; win_sel = w[3:0];
        op0 = a; op1 = b; op2 = c; op3 = d;
        k = cyc % 8;
        ev[k] = v;
        sa = int'($signed(a)); sb = int'($signed(b));
        sc = int'($signed(c)); sd = int'($signed(d));
        if (v) begin
            case (m)
                3'd0: begin
                    p = sa * sb;
                    m_acc = rs ? p : m_acc + p;
                    e0[k] = cond(m_acc, w); e1[k] = cond(p, w); et[k] = "R3 mac";
                end
                3'd1: begin
                    p = sb * sc;
                    e0[k] = cond(sa + p, w); e1[k] = cond(sa - p, w); et[k] = "R4 butterfly";
                end
                3'd2: begin
                    e0[k] = cond(sa + sb + sc + sd, w); e1[k] = cond(sa + sb, w); et[k] = "R5 tree";
                end
                3'd3: begin
                    e0[k] = cond((sa - sb) + (sc - sd), w); e1[k] = cond(sa - sb, w); et[k] = "R6 sod";
                end
                3'd4: begin
                    e0[k] = cond((sa + sb) - (sc + sd), w); e1[k] = cond(sa + sb, w); et[k] = "R6 dos";
                end
                3'd5: begin
                    old = m_lf;
                    m_lf = rs ? a : lf_step(m_lf);
                    e0[k] = m_lf; e1[k] = old; et[k] = "R9 lfsr";
                end
                3'd6: begin
                    m_ct = rs ? a : m_ct + b;
                    e0[k] = m_ct; e1[k] = {15'b0, m_ct == c}; et[k] = "R10 counter";
                end
                default: begin
                    e0[k] = (sa > sb) ? a : b;
                    e1[k] = {13'b0, sa > sb, sa == sb, sa < sb};
                    et[k] = "R11 compare";
                end
            endcase
        end
        cyc++;
    endtask

    task automatic bubble(input int n);
        for (int i = 0; i < n; i++) issue(1'b0, 3'd0, 1'b0, 0, 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #1000000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [2:0]  m;
        logic [15:0] a;
        bit          v, rs;
        void'($urandom(32'h5EED_1234));
        m_acc = 0; m_lf = 16'h0; m_ct = 16'h0;
        rst_n = 1'b0; in_valid = 1'b0; mode = 3'd0; restart = 1'b0; win_sel = '0;
        op0 = '0; op1 = '0; op2 = '0; op3 = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 reset out_valid", {15'b0, out_valid}, 16'h0);
        check("R2 reset res0", res0, 16'h0);
        check("R2 reset res1", res1, 16'h0);
        rst_n = 1'b1;
        bubble(3);
        @(negedge clk);
        check("R2 idle out_valid", {15'b0, out_valid}, 16'h0);
        check("R2 idle res0", res0, 16'h0);

        // R3 accumulate, a bubble in between, then restart
        issue(1, 3'd0, 1, 0, 16'd3, 16'd4, 0, 0);
        issue(1, 3'd0, 0, 0, 16'd5, 16'd6, 0, 0);
        issue(0, 3'd0, 1, 0, 16'd9, 16'd9, 0, 0);
        issue(1, 3'd0, 0, 0, 16'hFFFF, 16'd2, 0, 0);
        issue(1, 3'd0, 1, 0, 16'd7, 16'd7, 0, 0);
        // R8 saturation at both ends, R7 window 15
        issue(1, 3'd0, 1, 0, 16'h7FFF, 16'h7FFF, 0, 0);
        issue(1, 3'd0, 1, 0, 16'h8000, 16'h7FFF, 0, 0);
        issue(1, 3'd0, 1, 15, 16'h4000, 16'h4000, 0, 0);
        issue(1, 3'd0, 1, 15, 16'hC000, 16'h4000, 0, 0);
        // R4 butterfly with a negative weight
        issue(1, 3'd1, 0, 0, 16'd100, 16'd3, 16'hFFF9, 0);
        // R5, R6 and the window on their sums
        issue(1, 3'd2, 0, 0, 16'd10, 16'd20, 16'd30, 16'd40);
        issue(1, 3'd3, 0, 0, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000);
        issue(1, 3'd3, 0, 2, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000);
        issue(1, 3'd4, 0, 1, 16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF);
        // R9 LFSR from seed 1
        issue(1, 3'd5, 1, 0, 16'h0001, 0, 0, 0);
        for (int i = 0; i < 20; i++) issue(1, 3'd5, 0, 0, 0, 0, 0, 0);
        issue(1, 3'd5, 1, 0, 16'hACE1, 0, 0, 0);
        issue(1, 3'd5, 0, 0, 0, 0, 0, 0);
        // R10 counter wrap with a match flag
        issue(1, 3'd6, 1, 0, 16'hFFFE, 0, 16'hFFFE, 0);
        issue(1, 3'd6, 0, 0, 0, 16'd1, 16'h0000, 0);
        issue(1, 3'd6, 0, 0, 0, 16'd1, 16'h0000, 0);
        issue(1, 3'd6, 0, 0, 0, 16'hFFFF, 16'hFFFF, 0);
        // R11 compare: equal, greater, less
        issue(1, 3'd7, 0, 0, 16'h8000, 16'h8000, 0, 0);
        issue(1, 3'd7, 0, 0, 16'h0001, 16'hFFFF, 0, 0);
        issue(1, 3'd7, 0, 0, 16'h8000, 16'h7FFF, 0, 0);
        bubble(6);

        // Random mixed traffic
        for (int i = 0; i < 1500; i++) begin
            v  = ($urandom % 4) != 0;
            m  = 3'($urandom % 8);
            rs = ($urandom % 5) == 0;
            a  = 16'($urandom);
            if (m == 3'd5 && rs && a == 16'h0) a = 16'h1;
            issue(v, m, rs, int'($urandom % 16), a, 16'($urandom), 16'($urandom), 16'($urandom));
        end
        bubble(6);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule